// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the register file of a 32-bit load/store datapath that gives each procedure its own set of registers. The 32 register numbers that software sees are mapped onto a larger physical array. Ten of them name globals that every procedure shares. The other 22 name a window that a current-window pointer selects.

Each window has six incoming registers, ten locals and six outgoing registers. The outgoing registers of one window are the same storage as the incoming registers of the next deeper window. A caller places arguments in its outgoing registers and pulses the call strobe. The callee then finds those arguments in its incoming registers, and nothing is copied. Results go back the same way on the return strobe.

With the default parameters there are 8 windows, and each contributes 16 registers of its own, so the array holds 138 entries. A call made at the deepest window, or a return made at the outermost window, is refused and reported on a one-cycle status pulse. Saving windows to memory is left to logic outside the block.

A small controller tracks how deep the nesting is. It has three states:
- ST_OUTER: depth 0.
- ST_NESTED: any depth between 0 and the deepest.
- ST_DEEPEST: depth NWIN-1.

Its transitions are:
- T_DESCEND: a call taken from ST_OUTER or ST_NESTED. It goes to ST_NESTED, or to ST_DEEPEST when the new depth is NWIN-1.
- T_ASCEND: a return taken from ST_NESTED or ST_DEEPEST. It goes to ST_NESTED, or to ST_OUTER when the new depth is 0.
- T_REFUSE_CALL: a call at ST_DEEPEST. The state is kept and the overflow flag is raised.
- T_REFUSE_RET: a return at ST_OUTER. The state is kept and the underflow flag is raised.
- T_HOLD: no strobe, or both strobes together. Nothing changes.

Top module: `regwin_file`

## Requirements
- R1: After reset the window depth is 0, and both the overflow and underflow flags are low.
- R2: Registers r1 to r9 name the same storage at every depth. They are never remapped by a call or a return.
- R3: r0 reads as zero on both read ports, and a write to r0 is discarded.
- R4: A call moves one window deeper. The caller's r26..r31 are then read as the callee's r10..r15. At the deepest window, r26..r31 alias r10..r15 of depth 0.
- R5: A return moves one window shallower. Values the callee wrote into r10..r15 are then read as the caller's r26..r31.
- R6: Registers r16 to r25 are private to each depth. They keep their values across any number of deeper calls and the returns that follow.
- R7: A call at depth NWIN-1 leaves the depth unchanged. It raises the overflow flag in the cycle after the strobe edge, for one cycle per strobe cycle.
- R8: A return at depth 0 leaves the depth unchanged. It raises the underflow flag in the cycle after the strobe edge, for one cycle per strobe cycle.
- R9: If call and return are asserted together, the strobes are ignored. No flag is raised and the mapping does not change.
- R10: A write made in the same cycle as a call is placed through the mapping from before the call. A read of the register being written returns the old value until the clock edge, and the new value after it.
- R11: Reads are combinational. Read data follows the read selector within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_sel | input | 5 | Visible register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 5 | Visible register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Visible register number to write |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Call strobe: move one window deeper |
| ret_i | input | 1 | Return strobe: move one window shallower |
| ovf_o | output | 1 | Refused call, one-cycle pulse |
| unf_o | output | 1 | Refused return, one-cycle pulse |

## Verification
Read data is due in the same cycle as the selector. The bench sets the selector at a falling edge and samples 1 ns later, with no rising edge in between. A write, a call or a return takes effect at the next rising edge, so the bench makes the reads that depend on it only after that edge. The overflow and underflow flags are registered: the bench samples them 1 ns after the strobe edge, where they must be high, and again one edge later, where they must be low. The checks sweep every depth from 0 to the deepest and back, and compute each expected word from its depth and register index.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    // Nesting controller states
    typedef enum logic [1:0] {
        ST_OUTER,
        ST_NESTED,
        ST_DEEPEST
    } win_state_e;

    localparam int VIS_REGS = 32;
    localparam int SEL_W    = 5;
endpackage

// File: rtl/regwin_window_ctl.sv
module regwin_window_ctl
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int WPW = $clog2(NWIN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           call_i,
    input  logic           ret_i,
    output logic [WPW-1:0] cwp,
    output logic           ovf_o,
    output logic           unf_o
);
    localparam logic [WPW-1:0] LAST = WPW'(NWIN - 1);
    localparam logic [WPW-1:0] ONE  = WPW'(1);

    win_state_e     state, state_nxt;
    logic [WPW-1:0] cwp_nxt;
    logic           ovf_nxt, unf_nxt;
    logic           ev_call, ev_ret;

    assign ev_call = call_i && !ret_i;
    assign ev_ret  = ret_i && !call_i;

    always_comb begin
        state_nxt = state;
        cwp_nxt   = cwp;
        ovf_nxt   = 1'b0;
        unf_nxt   = 1'b0;
        unique case (state)
            ST_OUTER: begin
                if (ev_call) begin                       // T_DESCEND
                    cwp_nxt   = cwp + ONE;
                    state_nxt = (cwp + ONE == LAST) ? ST_DEEPEST : ST_NESTED;
                end else if (ev_ret) begin               // T_REFUSE_RET
                    unf_nxt = 1'b1;
                end
            end
            ST_NESTED: begin
                if (ev_call) begin                       // T_DESCEND
                    cwp_nxt   = cwp + ONE;
                    state_nxt = (cwp + ONE == LAST) ? ST_DEEPEST : ST_NESTED;
                end else if (ev_ret) begin               // T_ASCEND
                    cwp_nxt   = cwp - ONE;
                    state_nxt = (cwp == ONE) ? ST_OUTER : ST_NESTED;
                end
            end
            ST_DEEPEST: begin
                if (ev_call) begin                       // T_REFUSE_CALL
                    ovf_nxt = 1'b1;
                end else if (ev_ret) begin               // T_ASCEND
                    cwp_nxt   = cwp - ONE;
                    state_nxt = (cwp == ONE) ? ST_OUTER : ST_NESTED;
                end
            end
            default: begin
                state_nxt = ST_OUTER;
                cwp_nxt   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OUTER;
            cwp   <= '0;
        end else begin
            state <= state_nxt;
            cwp   <= cwp_nxt;
        end
    end

    // Registered status outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            ovf_o <= ovf_nxt;
            unf_o <= unf_nxt;
        end
    end
endmodule

// File: rtl/regwin_addr_map.sv
module regwin_addr_map
    import regwin_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int NGLOB = 10,
    parameter int NIN   = 6,
    parameter int NLOC  = 10,
    localparam int WPW   = $clog2(NWIN),
    localparam int NPHYS = NGLOB + NWIN * (NIN + NLOC),
    localparam int PW    = $clog2(NPHYS)
) (
    input  logic [WPW-1:0]   cwp,
    input  logic [SEL_W-1:0] sel,
    output logic [PW-1:0]    phys
);
    localparam int UNIQ    = NIN + NLOC;
    localparam int LOC_END = NGLOB + NIN + NLOC;

    int cur, nxt, idx, p;

    always_comb begin
        cur = int'(cwp);
        nxt = (cur == NWIN - 1) ? 0 : cur + 1;
        idx = int'(sel);
        if (idx < NGLOB)
            p = idx;
        else if (idx < LOC_END)
            p = NGLOB + cur * UNIQ + (idx - NGLOB);
        else
            p = NGLOB + nxt * UNIQ + (idx - LOC_END);
        phys = PW'(p);
    end
endmodule

// File: rtl/regwin_storage.sv
module regwin_storage #(
    parameter int NPHYS = 138,
    parameter int XLEN  = 32,
    parameter int NRD   = 2,
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [PW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [PW-1:0]   raddr [NRD],
    output logic [XLEN-1:0] rdata [NRD]
);
    logic [XLEN-1:0] mem [NPHYS];

    // Entry 0 is the hard-wired zero register
    always_ff @(posedge clk) begin
        if (we && waddr != '0)
            mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0 : mem[raddr[g]];
    end
endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import regwin_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int NGLOB = 10,
    parameter int NIN   = 6,
    parameter int NLOC  = 10,
    parameter int XLEN  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rd_a_sel,
    output logic [XLEN-1:0]  rd_a_data,
    input  logic [SEL_W-1:0] rd_b_sel,
    output logic [XLEN-1:0]  rd_b_data,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             call_i,
    input  logic             ret_i,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam int WPW   = $clog2(NWIN);
    localparam int NPHYS = NGLOB + NWIN * (NIN + NLOC);
    localparam int PW    = $clog2(NPHYS);
    localparam int NPORT = 3;   // two reads, one write

    logic [WPW-1:0]   cwp;
    logic [SEL_W-1:0] sel_v  [NPORT];
    logic [PW-1:0]    phys_v [NPORT];
    logic [PW-1:0]    rd_phys [2];
    logic [XLEN-1:0]  rd_val  [2];

    assign sel_v[0] = rd_a_sel;
    assign sel_v[1] = rd_b_sel;
    assign sel_v[2] = wr_sel;

    regwin_window_ctl #(.NWIN(NWIN)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .call_i(call_i),
        .ret_i (ret_i),
        .cwp   (cwp),
        .ovf_o (ovf_o),
        .unf_o (unf_o)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_map
        regwin_addr_map #(
            .NWIN(NWIN), .NGLOB(NGLOB), .NIN(NIN), .NLOC(NLOC)
        ) u_map (
            .cwp (cwp),
            .sel (sel_v[g]),
            .phys(phys_v[g])
        );
    end

    assign rd_phys[0] = phys_v[0];
    assign rd_phys[1] = phys_v[1];

    regwin_storage #(.NPHYS(NPHYS), .XLEN(XLEN), .NRD(2)) u_mem (
        .clk  (clk),
        .we   (wr_en),
        .waddr(phys_v[2]),
        .wdata(wr_data),
        .raddr(rd_phys),
        .rdata(rd_val)
    );

    assign rd_a_data = rd_val[0];
    assign rd_b_data = rd_val[1];
endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    localparam int WPW = $clog2(NWIN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            call_i,
    input logic            ret_i,
    input logic            ovf_o,
    input logic            unf_o,
    input logic [WPW-1:0]  cwp,
    input logic [4:0]      rd_a_sel,
    input logic [XLEN-1:0] rd_a_data
);
    localparam logic [WPW-1:0] LAST = WPW'(NWIN - 1);

    p_r0_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == 5'd0) |-> (rd_a_data == '0));

    p_call_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && cwp != LAST) |=> (cwp == $past(cwp) + WPW'(1)) && !ovf_o);

    p_ret_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && cwp != '0) |=> (cwp == $past(cwp) - WPW'(1)) && !unf_o);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && cwp == LAST) |=> ovf_o && $stable(cwp));

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && cwp == '0) |=> unf_o && $stable(cwp));

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));

    p_both_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> $stable(cwp) && !ovf_o && !unf_o);
endmodule

bind regwin_file regwin_file_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o),
    .cwp      (cwp),
    .rd_a_sel (rd_a_sel),
    .rd_a_data(rd_a_data)
);

// File: tb/sim_regwin_file.sv
`timescale 1ns/100ps
module sim_regwin_file;
    localparam int NWIN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
    logic        ovf_o, unf_o;
    int          n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    regwin_file u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .call_i(call_i), .ret_i(ret_i),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    function automatic logic [31:0] loc_v(int d, int i);
        return 32'hA000_0000 | (d << 8) | i;
    endfunction
    function automatic logic [31:0] out_v(int d, int i);
        return 32'hB000_0000 | (d << 8) | i;
    endfunction
    function automatic logic [31:0] glb_v(int i);
        return 32'hC000_0000 | i;
    endfunction
    function automatic logic [31:0] in0_v(int i);
        return 32'hD000_0000 | i;
    endfunction
    function automatic logic [31:0] res_v(int d, int i);
        return 32'hE000_0000 | (d << 8) | i;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 5'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rchk(input int sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_a_sel = 5'(sel); rd_b_sel = 5'(sel);
        #1;
        chk(rd_a_data == exp, req, rd_a_data, exp);
        chk(rd_b_data == exp, req, rd_b_data, exp);
    endtask

    task automatic strobe(input logic c, input logic r, input logic eo, input logic eu, input string req);
        @(negedge clk);
        call_i = c; ret_i = r;
        @(posedge clk); #1;
        chk(ovf_o == eo, {req, " ovf"}, 32'(ovf_o), 32'(eo));
        chk(unf_o == eu, {req, " unf"}, 32'(unf_o), 32'(eu));
        @(negedge clk);
        call_i = 1'b0; ret_i = 1'b0;
        @(posedge clk); #1;
        chk(!ovf_o && !unf_o, {req, " pulse width"}, 32'({ovf_o, unf_o}), 32'd0);
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: flags low after reset
        chk(!ovf_o && !unf_o, "R1 flags", 32'({ovf_o, unf_o}), 32'd0);

        // R3: r0 write discarded
        wr(0, 32'hFFFF_FFFF);
        rchk(0, 32'd0, "R3 r0 zero");

        for (int i = 1; i < 10; i++) wr(i, glb_v(i));
        for (int i = 0; i < 6; i++) wr(10 + i, in0_v(i));

        // Descend through every depth
        for (int d = 0; d < NWIN; d++) begin
            if (d > 0)
                for (int i = 0; i < 6; i++) rchk(10 + i, out_v(d - 1, i), "R4 callee sees args");
            for (int i = 1; i < 10; i++) rchk(i, glb_v(i), "R2 globals");
            for (int i = 0; i < 10; i++) wr(16 + i, loc_v(d, i));
            if (d < NWIN - 1) begin
                for (int i = 0; i < 6; i++) wr(26 + i, out_v(d, i));
                strobe(1'b1, 1'b0, 1'b0, 1'b0, "R4 call");
            end
        end

        // R4: deepest outgoing wraps onto depth 0 incoming
        for (int i = 0; i < 6; i++) rchk(26 + i, in0_v(i), "R4 wrap");
        // R7: refused call
        strobe(1'b1, 1'b0, 1'b1, 1'b0, "R7 overflow");
        for (int i = 0; i < 10; i++) rchk(16 + i, loc_v(NWIN - 1, i), "R7 depth kept");

        // Ascend back with results
        for (int d = NWIN - 1; d > 0; d--) begin
            for (int i = 0; i < 6; i++) wr(10 + i, res_v(d, i));
            strobe(1'b0, 1'b1, 1'b0, 1'b0, "R5 return");
            for (int i = 0; i < 6; i++) rchk(26 + i, res_v(d, i), "R5 results");
            for (int i = 0; i < 10; i++) rchk(16 + i, loc_v(d - 1, i), "R6 locals");
        end
        for (int i = 0; i < 6; i++) rchk(10 + i, in0_v(i), "R1 depth 0 inputs");

        // R9: both strobes together are ignored
        strobe(1'b1, 1'b1, 1'b0, 1'b0, "R9 both");
        rchk(26, res_v(1, 0), "R9 mapping kept");
        rchk(16, loc_v(0, 0), "R9 mapping kept");

        // R8: refused return at depth 0
        strobe(1'b0, 1'b1, 1'b0, 1'b1, "R8 underflow");
        rchk(16, loc_v(0, 0), "R8 depth kept");

        // R10: write together with call uses old mapping
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 5'd16; wr_data = 32'h1234_5678; call_i = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; call_i = 1'b0;
        rchk(16, loc_v(1, 0), "R10 callee local untouched");
        strobe(1'b0, 1'b1, 1'b0, 1'b0, "R10 return");
        rchk(16, 32'h1234_5678, "R10 write landed in caller");

        // R10/R11: read during write gives old then new value
        @(negedge clk);
        rd_a_sel = 5'd17; wr_en = 1'b1; wr_sel = 5'd17; wr_data = 32'h5A5A_0017;
        #1;
        chk(rd_a_data == loc_v(0, 1), "R10 old value", rd_a_data, loc_v(0, 1));
        @(posedge clk); #1;
        chk(rd_a_data == 32'h5A5A_0017, "R10 new value", rd_a_data, 32'h5A5A_0017);
        @(negedge clk);
        wr_en = 1'b0;
        rd_a_sel = 5'd3;
        #1;
        chk(rd_a_data == glb_v(3), "R11 same-cycle read", rd_a_data, glb_v(3));
        rd_a_sel = 5'd0;
        #1;
        chk(rd_a_data == 32'd0, "R3 r0 after writes", rd_a_data, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule